// File: doc/BRIEF.md
# Keyboard-Controller Host Interface

This block sits between a host register bus and an embedded core that runs keyboard and pointing-device firmware. The host sees four byte registers: two it reads (an output byte and a status byte) and two it writes (a data byte and a command byte). Each of the four has its own base-address input, so software can place them anywhere in the host address space. The customary placement is the output and data-in registers at 0x60 and the status and command registers at 0x64. The host bus is reduced to a single address, a read strobe and a write strobe, each lasting one clock.

Output-full and input-full flags carry the handshake. The core loads a byte for the host, tagging it as keyboard or auxiliary (mouse) traffic. The host then learns of it by polling status or through the keyboard or auxiliary interrupt line. Host reads of the output byte empty the buffer. Host writes land in an input holding register, which the core drains through a valid/ready port. A separately enabled core interrupt reports that the output buffer is empty.

Top module: `kbc_host_if`

## Requirements
- R1: After reset both buffer flags are 0, `core_in_valid` is 0, both host interrupt lines sit at their inactive level, and a host read of status returns 0x00.
- R2: A `core_out_wr` strobe stores the byte and sets OBF (status bit 0, also on `core_obf`) at the next edge. A host read at the data-out base returns the stored byte on `host_rdata` in the same cycle and clears OBF at the following edge, unless a core write occurs in that same cycle.
- R3: A core write while OBF is already 1 replaces the byte, leaves OBF at 1, and produces no new edge-mode pulse.
- R4: A host write at the data-in base or the command base sets IBF (status bit 1) and stores the byte. Status bit 3 becomes 0 for a data-in write and 1 for a command write, and keeps that value until the next host write.
- R5: `core_in_valid` equals IBF and `core_in_data`/`core_in_cmd` stay stable while it is high. A cycle with `core_in_valid` and `core_in_ready` both high clears IBF at the next edge. There is no back-pressure toward the host: a host write while IBF is 1 overwrites the byte and the command flag.
- R6: `core_flags_wr` loads the four core-owned status bits: `core_flags_data` bit 0 goes to status bit 2, bit 1 to status bit 4, bit 2 to status bit 6, and bit 3 to status bit 7.
- R7: `core_out_aux` sampled with a core write is shown in status bit 5. It routes the interrupt for that byte to `irq_aux` when 1 and to `irq_kbd` when 0.
- R8: With `host_irq_mode` = 3'b000 (level) and `host_irq_en` = 1, the selected line is active while OBF is 1 and returns inactive once a host read clears OBF. The active level is high when `host_irq_pol` = 0 and low when it is 1. The inactive level equals `host_irq_pol`.
- R9: With any other `host_irq_mode` value and `host_irq_en` = 1, the selected line is active for exactly one cycle, the first cycle in which OBF is 1 after being 0.
- R10: With `host_irq_en` = 0, both host lines stay at the inactive level whatever OBF does.
- R11: `core_obe_irq` is 1 exactly when `core_obe_en` is 1 and OBF is 0.
- R12: Only an address equal to a base input selects that register. Host strobes at any other address change no flag, and reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Host register address |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Host read byte, valid in the strobe cycle |
| base_dout | input | ADDR_W | Base address of the output byte (read) |
| base_stat | input | ADDR_W | Base address of the status byte (read) |
| base_din | input | ADDR_W | Base address of the data-in byte (write) |
| base_cmd | input | ADDR_W | Base address of the command byte (write) |
| core_out_wr | input | 1 | Core strobe loading the output byte |
| core_out_data | input | DATA_W | Byte for the host |
| core_out_aux | input | 1 | 1 tags the byte as auxiliary-device traffic |
| core_obf | output | 1 | Output buffer full flag |
| core_in_valid | output | 1 | Input byte waiting for the core (IBF) |
| core_in_ready | input | 1 | Core accepts the input byte |
| core_in_data | output | DATA_W | Byte written by the host |
| core_in_cmd | output | 1 | 1 if that byte came through the command base |
| core_flags_wr | input | 1 | Core strobe loading the core-owned status bits |
| core_flags_data | input | 4 | Values of status bits 7, 6, 4, 2 (MSB first) |
| host_irq_mode | input | 3 | 3'b000 level mode, other values edge-pulse mode |
| host_irq_pol | input | 1 | 1 makes the host lines active low |
| host_irq_en | input | 1 | Host interrupt enable |
| core_obe_en | input | 1 | Output-empty core interrupt enable |
| irq_kbd | output | 1 | Keyboard host interrupt line |
| irq_aux | output | 1 | Auxiliary-device host interrupt line |
| core_obe_irq | output | 1 | Output-empty interrupt to the core |

## Verification
A wrong flag state is visible at the ports within a cycle. A stuck OBF keeps the level interrupt active after a host read and holds `core_obe_irq` low. A stale IBF leaves `core_in_valid` high after a handshake. A wrong command flag shows up in status bit 3 on the next status read. A lost edge-detect register shows up as a repeated or missing pulse in the cycle after a core write. A wrong routing of the auxiliary tag swaps the two host lines on the first byte written.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  // Status byte bit positions (host software decodes these)
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_SYS = 2;
  localparam int ST_CMD = 3;
  localparam int ST_U4  = 4;
  localparam int ST_AUX = 5;
  localparam int ST_U6  = 6;
  localparam int ST_U7  = 7;
  localparam int ST_W   = 8;

  localparam int NUM_REGS = 4;
  typedef enum logic [1:0] {
    REG_DOUT = 2'd0,
    REG_STAT = 2'd1,
    REG_DIN  = 2'd2,
    REG_CMD  = 2'd3
  } reg_sel_e;

  localparam logic [2:0] IRQ_MODE_LEVEL = 3'b000;
endpackage

// File: rtl/kbc_addr_decode.sv
module kbc_addr_decode
  import kbc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]               host_addr,
  input  logic                            host_rd,
  input  logic                            host_wr,
  input  logic [NUM_REGS-1:0][ADDR_W-1:0] bases,
  output logic [NUM_REGS-1:0]             sel
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_port
    logic hit;
    assign hit = (host_addr == bases[i]);
    if (i == int'(REG_DOUT) || i == int'(REG_STAT)) begin : g_rd
      assign sel[i] = hit & host_rd;
    end else begin : g_wr
      assign sel[i] = hit & host_wr;
    end
  end
endmodule

// File: rtl/kbc_buffers.sv
module kbc_buffers
  import kbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_wr,
  input  logic [DATA_W-1:0] out_data,
  input  logic              out_aux,
  input  logic              rd_dout,
  input  logic              wr_din,
  input  logic              wr_cmd,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              in_ready,
  input  logic              flags_wr,
  input  logic [3:0]        flags_data,
  output logic [DATA_W-1:0] out_byte,
  output logic [DATA_W-1:0] in_byte,
  output logic              obf,
  output logic              ibf,
  output logic              cmd,
  output logic              aux,
  output logic [DATA_W-1:0] status
);
  logic [3:0] user_q;
  logic       host_in_wr;

  assign host_in_wr = wr_din | wr_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_byte <= '0;
      in_byte  <= '0;
      obf      <= 1'b0;
      ibf      <= 1'b0;
      cmd      <= 1'b0;
      aux      <= 1'b0;
      user_q   <= '0;
    end else begin
      if (out_wr) begin
        out_byte <= out_data;
        obf      <= 1'b1;
        aux      <= out_aux;
      end else if (rd_dout) begin
        obf <= 1'b0;
      end
      if (host_in_wr) begin
        in_byte <= host_wdata;
        ibf     <= 1'b1;
        cmd     <= wr_cmd;
      end else if (ibf && in_ready) begin
        ibf <= 1'b0;
      end
      if (flags_wr) user_q <= flags_data;
    end
  end

  always_comb begin
    status         = '0;
    status[ST_OBF] = obf;
    status[ST_IBF] = ibf;
    status[ST_SYS] = user_q[0];
    status[ST_CMD] = cmd;
    status[ST_U4]  = user_q[1];
    status[ST_AUX] = aux;
    status[ST_U6]  = user_q[2];
    status[ST_U7]  = user_q[3];
  end

  a_r2_core_write_sets_obf: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |=> obf);
  a_r2_host_read_clears_obf: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dout && !out_wr) |=> !obf);
  a_r3_overwrite_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (obf && out_wr) |=> (obf && out_byte == $past(out_data)));
  a_r4_host_write_sets_ibf: assert property (@(posedge clk) disable iff (!rst_n)
    host_in_wr |=> (ibf && in_byte == $past(host_wdata)));
  a_r5_handshake_clears_ibf: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf && in_ready && !host_in_wr) |=> !ibf);
  a_r5_data_stable_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf && !in_ready && !host_in_wr) |=> (ibf && $stable(in_byte) && $stable(cmd)));
endmodule

// File: rtl/kbc_irq.sv
module kbc_irq
  import kbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       obf,
  input  logic       aux,
  input  logic [2:0] mode,
  input  logic       pol,
  input  logic       en,
  input  logic       obe_en,
  output logic       irq_kbd,
  output logic       irq_aux,
  output logic       obe_irq
);
  logic obf_d;
  logic level_mode;
  logic obf_rise;
  logic active;

  always_ff @(posedge clk) begin
    if (!rst_n) obf_d <= 1'b0;
    else        obf_d <= obf;
  end

  assign level_mode = (mode == IRQ_MODE_LEVEL);
  assign obf_rise   = obf & ~obf_d;
  assign active     = en & (level_mode ? obf : obf_rise);
  assign irq_kbd    = (active & ~aux) ^ pol;
  assign irq_aux    = (active &  aux) ^ pol;
  assign obe_irq    = obe_en & ~obf;

  a_r8_level_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && !obf) |-> (irq_kbd == pol && irq_aux == pol));
  a_r9_pulse_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && irq_kbd != pol) |=> (mode == IRQ_MODE_LEVEL || irq_kbd == pol));
  a_r10_disabled_lines_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> (irq_kbd == pol && irq_aux == pol));
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [ADDR_W-1:0] base_dout,
  input  logic [ADDR_W-1:0] base_stat,
  input  logic [ADDR_W-1:0] base_din,
  input  logic [ADDR_W-1:0] base_cmd,
  input  logic              core_out_wr,
  input  logic [DATA_W-1:0] core_out_data,
  input  logic              core_out_aux,
  output logic              core_obf,
  output logic              core_in_valid,
  input  logic              core_in_ready,
  output logic [DATA_W-1:0] core_in_data,
  output logic              core_in_cmd,
  input  logic              core_flags_wr,
  input  logic [3:0]        core_flags_data,
  input  logic [2:0]        host_irq_mode,
  input  logic              host_irq_pol,
  input  logic              host_irq_en,
  input  logic              core_obe_en,
  output logic              irq_kbd,
  output logic              irq_aux,
  output logic              core_obe_irq
);
  logic [NUM_REGS-1:0][ADDR_W-1:0] bases;
  logic [NUM_REGS-1:0]             sel;
  logic [DATA_W-1:0]               out_byte;
  logic [DATA_W-1:0]               status;
  logic                            obf;
  logic                            ibf;
  logic                            aux;

  always_comb begin
    bases[REG_DOUT] = base_dout;
    bases[REG_STAT] = base_stat;
    bases[REG_DIN]  = base_din;
    bases[REG_CMD]  = base_cmd;
  end

  kbc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .host_addr (host_addr),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .bases     (bases),
    .sel       (sel)
  );

  kbc_buffers #(.DATA_W(DATA_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_wr     (core_out_wr),
    .out_data   (core_out_data),
    .out_aux    (core_out_aux),
    .rd_dout    (sel[REG_DOUT]),
    .wr_din     (sel[REG_DIN]),
    .wr_cmd     (sel[REG_CMD]),
    .host_wdata (host_wdata),
    .in_ready   (core_in_ready),
    .flags_wr   (core_flags_wr),
    .flags_data (core_flags_data),
    .out_byte   (out_byte),
    .in_byte    (core_in_data),
    .obf        (obf),
    .ibf        (ibf),
    .cmd        (core_in_cmd),
    .aux        (aux),
    .status     (status)
  );

  kbc_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .obf     (obf),
    .aux     (aux),
    .mode    (host_irq_mode),
    .pol     (host_irq_pol),
    .en      (host_irq_en),
    .obe_en  (core_obe_en),
    .irq_kbd (irq_kbd),
    .irq_aux (irq_aux),
    .obe_irq (core_obe_irq)
  );

  always_comb begin
    if (sel[REG_DOUT])      host_rdata = out_byte;
    else if (sel[REG_STAT]) host_rdata = status;
    else                    host_rdata = '0;
  end

  assign core_obf      = obf;
  assign core_in_valid = ibf;

  a_r12_unmatched_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr != base_dout && host_addr != base_stat) |-> (host_rdata == '0));
  a_r11_obe_tracks_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (core_obe_en && $past(core_out_wr)) |-> !core_obe_irq);
endmodule

// File: tb/kbc_host_if_test.sv
module kbc_host_if_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] host_addr;
  logic        host_rd, host_wr;
  logic [7:0]  host_wdata, host_rdata;
  logic [15:0] base_dout, base_stat, base_din, base_cmd;
  logic        core_out_wr;
  logic [7:0]  core_out_data;
  logic        core_out_aux;
  logic        core_obf, core_in_valid, core_in_ready, core_in_cmd;
  logic [7:0]  core_in_data;
  logic        core_flags_wr;
  logic [3:0]  core_flags_data;
  logic [2:0]  host_irq_mode;
  logic        host_irq_pol, host_irq_en, core_obe_en;
  logic        irq_kbd, irq_aux, core_obe_irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  kbc_host_if uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .base_dout(base_dout), .base_stat(base_stat), .base_din(base_din),
    .base_cmd(base_cmd), .core_out_wr(core_out_wr), .core_out_data(core_out_data),
    .core_out_aux(core_out_aux), .core_obf(core_obf), .core_in_valid(core_in_valid),
    .core_in_ready(core_in_ready), .core_in_data(core_in_data),
    .core_in_cmd(core_in_cmd), .core_flags_wr(core_flags_wr),
    .core_flags_data(core_flags_data), .host_irq_mode(host_irq_mode),
    .host_irq_pol(host_irq_pol), .host_irq_en(host_irq_en),
    .core_obe_en(core_obe_en), .irq_kbd(irq_kbd), .irq_aux(irq_aux),
    .core_obe_irq(core_obe_irq)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic host_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic host_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic core_put(input logic [7:0] d, input logic aux);
    @(negedge clk);
    core_out_data = d; core_out_aux = aux; core_out_wr = 1'b1;
    @(negedge clk);
    core_out_wr = 1'b0;
  endtask

  task automatic core_flags(input logic [3:0] f);
    @(negedge clk);
    core_flags_data = f; core_flags_wr = 1'b1;
    @(negedge clk);
    core_flags_wr = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 obf", {7'd0, core_obf}, 8'h00);
    check("R1 in_valid", {7'd0, core_in_valid}, 8'h00);
    check("R1 irq lines", {6'd0, irq_kbd, irq_aux}, 8'h00);
    check("R11 obe irq at reset", {7'd0, core_obe_irq}, 8'h01);
    rst_n = 1'b1;
    host_read(16'h0064, d);
    check("R1 status", d, 8'h00);
  endtask

  task automatic t_out_path;
    logic [7:0] d;
    core_put(8'hA5, 1'b0);
    check("R2 obf set", {7'd0, core_obf}, 8'h01);
    host_read(16'h0060, d);
    check("R2 read data", d, 8'hA5);
    check("R2 obf cleared", {7'd0, core_obf}, 8'h00);
  endtask

  task automatic t_overwrite;
    logic [7:0] d;
    host_irq_mode = 3'b001;
    core_put(8'h11, 1'b0);
    check("R9 first pulse", {7'd0, irq_kbd}, 8'h01);
    @(negedge clk);
    check("R9 pulse ends", {7'd0, irq_kbd}, 8'h00);
    core_put(8'h22, 1'b0);
    check("R3 obf stays", {7'd0, core_obf}, 8'h01);
    check("R3 no new pulse", {7'd0, irq_kbd}, 8'h00);
    host_read(16'h0060, d);
    check("R3 newest byte", d, 8'h22);
    host_irq_mode = 3'b000;
  endtask

  task automatic t_in_path;
    logic [7:0] d;
    host_write(16'h0060, 8'h3C);
    check("R4 ibf data", {7'd0, core_in_valid}, 8'h01);
    check("R4 data flag", {7'd0, core_in_cmd}, 8'h00);
    check("R4 byte", core_in_data, 8'h3C);
    host_read(16'h0064, d);
    check("R4 status data write", d, 8'h02);
    host_write(16'h0064, 8'hD4);
    check("R5 overwrite byte", core_in_data, 8'hD4);
    check("R4 cmd flag", {7'd0, core_in_cmd}, 8'h01);
    host_read(16'h0064, d);
    check("R4 status cmd write", d, 8'h0A);
  endtask

  task automatic t_handshake;
    repeat (2) @(negedge clk);
    check("R5 held without ready", {7'd0, core_in_valid}, 8'h01);
    check("R5 data stable", core_in_data, 8'hD4);
    core_in_ready = 1'b1;
    @(negedge clk);
    core_in_ready = 1'b0;
    check("R5 handshake clears", {7'd0, core_in_valid}, 8'h00);
  endtask

  task automatic t_status_bits;
    logic [7:0] d;
    core_flags(4'b1111);
    host_read(16'h0064, d);
    check("R6 all core bits", d, 8'hDC);
    core_flags(4'b0101);
    host_read(16'h0064, d);
    check("R6 mapping", d, 8'h4C);
    core_flags(4'b0000);
  endtask

  task automatic t_aux;
    logic [7:0] d;
    core_put(8'h77, 1'b1);
    host_read(16'h0064, d);
    check("R7 aux status", d, 8'h29);
    check("R7 aux line", {6'd0, irq_kbd, irq_aux}, 8'h01);
    host_read(16'h0060, d);
    check("R7 aux byte", d, 8'h77);
    check("R8 aux released", {6'd0, irq_kbd, irq_aux}, 8'h00);
  endtask

  task automatic t_level;
    logic [7:0] d;
    core_put(8'h10, 1'b0);
    repeat (3) @(negedge clk);
    check("R8 level held", {6'd0, irq_kbd, irq_aux}, 8'h02);
    host_read(16'h0060, d);
    check("R8 level released", {6'd0, irq_kbd, irq_aux}, 8'h00);
    host_irq_pol = 1'b1;
    @(negedge clk);
    check("R8 inverted idle", {6'd0, irq_kbd, irq_aux}, 8'h03);
    core_put(8'h20, 1'b0);
    check("R8 active low", {6'd0, irq_kbd, irq_aux}, 8'h01);
    host_read(16'h0060, d);
    check("R8 active low released", {6'd0, irq_kbd, irq_aux}, 8'h03);
    host_irq_pol = 1'b0;
  endtask

  task automatic t_pulse;
    logic [7:0] d;
    host_irq_mode = 3'b010;
    core_put(8'h33, 1'b1);
    check("R9 aux pulse", {6'd0, irq_kbd, irq_aux}, 8'h01);
    @(negedge clk);
    check("R9 aux pulse ends", {6'd0, irq_kbd, irq_aux}, 8'h00);
    host_read(16'h0060, d);
    host_irq_mode = 3'b000;
  endtask

  task automatic t_disable;
    logic [7:0] d;
    host_irq_en = 1'b0;
    core_put(8'h44, 1'b0);
    @(negedge clk);
    check("R10 lines idle", {6'd0, irq_kbd, irq_aux}, 8'h00);
    host_read(16'h0060, d);
    host_irq_en = 1'b1;
  endtask

  task automatic t_obe;
    logic [7:0] d;
    check("R11 empty irq", {7'd0, core_obe_irq}, 8'h01);
    core_put(8'h55, 1'b0);
    check("R11 full no irq", {7'd0, core_obe_irq}, 8'h00);
    host_read(16'h0060, d);
    check("R11 empty again", {7'd0, core_obe_irq}, 8'h01);
    core_obe_en = 1'b0;
    #1 check("R11 disabled", {7'd0, core_obe_irq}, 8'h00);
    core_obe_en = 1'b1;
  endtask

  task automatic t_addr;
    logic [7:0] d;
    base_dout = 16'h0062;
    core_put(8'h5A, 1'b0);
    host_read(16'h0060, d);
    check("R12 old base reads zero", d, 8'h00);
    check("R12 obf untouched", {7'd0, core_obf}, 8'h01);
    host_read(16'h0062, d);
    check("R12 new base data", d, 8'h5A);
    check("R12 new base clears", {7'd0, core_obf}, 8'h00);
    host_write(16'h0061, 8'h99);
    check("R12 stray write", {7'd0, core_in_valid}, 8'h00);
    base_dout = 16'h0060;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    host_addr = '0; host_rd = 0; host_wr = 0; host_wdata = '0;
    base_dout = 16'h0060; base_stat = 16'h0064;
    base_din = 16'h0060; base_cmd = 16'h0064;
    core_out_wr = 0; core_out_data = '0; core_out_aux = 0;
    core_in_ready = 0; core_flags_wr = 0; core_flags_data = '0;
    host_irq_mode = 3'b000; host_irq_pol = 0; host_irq_en = 1; core_obe_en = 1;
    t_reset();
    t_out_path();
    t_overwrite();
    t_in_path();
    t_handshake();
    t_status_bits();
    t_aux();
    t_level();
    t_pulse();
    t_disable();
    t_obe();
    t_addr();
    report();
    $finish;
  end
endmodule